// File: doc/BRIEF.md
# Programmable Timer and Interrupt Controller

This CPU-side peripheral pairs a reloadable down-counting timer with a three-source interrupt arbiter. The timer counts down from a 7-bit reload value once every 1024 CPU clocks. When it steps below zero it reloads and raises a timer pending flag. The arbiter combines that flag with two level-sensitive request lines, one from an external device and one from the video unit. It applies a per-source disable mask and a fixed priority, and presents a registered interrupt request together with the 16-bit vector address of the winning source.

The CPU reaches the block over a small byte-wide register bus. The bus has a window select, a 2-bit offset, a write strobe and write data. Read data is combinational and always shows the register the current window and offset point at. Reading has no side effects. The CPU core flags the last cycle of each instruction on `insn_end`. Arbitration is sampled only in that cycle, and the request is suppressed while the CPU's interrupt-disable flag `cpu_int_mask` is high.

Top module: `cpu_timer_intc`

## Requirements
- R1: After reset, `irq_req` is 0 and `irq_vector` is 0x0000. The timer count, reload value, enable, prescaler, disable mask and timer pending flag are all 0.
- R2: A write with `reg_win`=0 and `reg_off[0]`=0 stores `reg_wdata[6:0]` as the reload value and does not change the count. A read with `reg_win`=0 at any offset returns the count in bits 6:0, with bit 7 at 0.
- R3: A write with `reg_win`=0 and `reg_off[0]`=1 sets the timer enable to `reg_wdata[0]`. Writing 1 copies the reload value into the count and restarts the prescaler. While the enable is 0, the count does not change.
- R4: While enabled, the count drops by one on the PRESCALE_DIV-th clock edge after the enabling write, and again on every PRESCALE_DIV-th edge after that.
- R5: When the count is 0 at a prescaler tick, it is loaded from the reload value instead of decrementing, and the timer pending flag is set.
- R6: With `reg_win`=1 and offset 2, the disable mask is written from `reg_wdata[2:0]` and read back in bits 2:0. Bit 0 masks the external source, bit 1 the video source and bit 2 the timer.
- R7: With `reg_win`=1 and offset 3, a read returns the pending set with the same bit order: bit 0 external, bit 1 video, bit 2 timer. The external and video bits follow `ext_irq_lvl` and `vid_irq_lvl` in the same cycle.
- R8: Any write with `reg_win`=1 and offset 3 clears the timer pending flag and nothing else. If a timer reload happens in the same cycle as this write, the flag ends up set.
- R9: A source takes part in arbitration only when it is pending and its disable bit is 0. External beats video, and video beats timer. The vectors are 0xFFF6 for external, 0xFFF8 for video and 0xFFFA for timer.
- R10: `irq_req` and `irq_vector` change only on an edge where `insn_end` is 1. At such an edge `irq_req` becomes 1 exactly when some source takes part and `cpu_int_mask` is 0. `irq_vector` is loaded only when `irq_req` becomes 1, and otherwise keeps its last value.
- R11: In window 1, offsets 0 and 1 read as 0x00, and writes there change no register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_win | input | 1 | Window select: 0 timer, 1 interrupt control |
| reg_off | input | 2 | Register offset within the window |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register (combinational) |
| ext_irq_lvl | input | 1 | External interrupt level |
| vid_irq_lvl | input | 1 | Video interrupt level |
| cpu_int_mask | input | 1 | CPU interrupt-disable flag |
| insn_end | input | 1 | High in the last cycle of a CPU instruction |
| irq_req | output | 1 | Registered interrupt request |
| irq_vector | output | 16 | Vector address of the winning source |

## Verification
The hardest case to reach from the ports is a status clear that arrives in the exact clock edge where the timer reloads from zero. Only one edge in 1024 qualifies, so free-running stimulus almost never hits it. The bench loads a reload value of zero and enables the timer. It then counts exactly PRESCALE_DIV-1 edges before issuing the clearing write, so that the write lands on the tick and the flag must stay set. A behavioural model running next to the design also compares request, vector and read data on every clock. Part of this runs under random source levels, masks and bus writes.

// File: rtl/tmrint_pkg.sv
package tmrint_pkg;

  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_VID = 2'd1,
    SRC_TMR = 2'd2
  } src_e;

  localparam logic [15:0] VEC_EXT = 16'hFFF6;
  localparam logic [15:0] VEC_VID = 16'hFFF8;
  localparam logic [15:0] VEC_TMR = 16'hFFFA;

  // vector address belonging to one source index
  function automatic logic [15:0] vec_of(input int idx);
    logic [15:0] v;
    case (idx)
      0:       v = VEC_EXT;
      1:       v = VEC_VID;
      default: v = VEC_TMR;
    endcase
    return v;
  endfunction

  // sources that may take part: pending and not masked
  function automatic logic [NSRC-1:0] live_sources(input logic [NSRC-1:0] pend,
                                                   input logic [NSRC-1:0] dis);
    return pend & ~dis;
  endfunction

  // lowest index wins; scan from the weakest so the strongest overwrites
  function automatic logic [15:0] pick_vector(input logic [NSRC-1:0] live);
    logic [15:0] v;
    v = VEC_TMR;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) v = vec_of(i);
    end
    return v;
  endfunction

endpackage

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int PRESCALE_DIV = 1024,
  parameter int CNT_W        = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_we,
  input  logic [CNT_W-1:0] latch_d,
  input  logic             ctl_we,
  input  logic             ctl_en,
  input  logic             clr_pend,
  output logic [CNT_W-1:0] count,
  output logic             pend,
  output logic             tick,
  output logic             wrap
);

  localparam int PW = $clog2(PRESCALE_DIV);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE_DIV - 1);

  logic [CNT_W-1:0] reload;
  logic [PW-1:0]    pre;
  logic             en;
  logic             restart;

  assign tick    = en && (pre == PRE_LAST);
  assign wrap    = tick && (count == '0);
  assign restart = ctl_we && ctl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
    end else if (latch_we) begin
      reload <= latch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
    end else if (ctl_we) begin
      en <= ctl_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre   <= '0;
      count <= '0;
    end else if (restart) begin
      pre   <= '0;
      count <= reload;
    end else if (en) begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) begin
        count <= wrap ? reload : count - 1'b1;
      end
    end
  end

  // reload event takes precedence over a clear in the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
    end else if (wrap) begin
      pend <= 1'b1;
    end else if (clr_pend) begin
      pend <= 1'b0;
    end
  end

  p_hold_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ctl_we) |=> $stable(count));

  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctl_we) |=> !tick);

  p_wrap_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (pend && count == $past(reload)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && !wrap) |=> !pend);

endmodule

// File: rtl/tmrint_regs.sv
module tmrint_regs #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7,
  parameter int NSRC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_win,
  input  logic [1:0]        bus_off,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  tmr_count,
  input  logic [NSRC-1:0]   src_pend,
  output logic              latch_we,
  output logic [CNT_W-1:0]  latch_d,
  output logic              ctl_we,
  output logic              ctl_en,
  output logic              clr_tmr,
  output logic [NSRC-1:0]   src_dis,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam logic       WIN_TMR  = 1'b0;
  localparam logic       WIN_INT  = 1'b1;
  localparam logic [1:0] OFF_MASK = 2'd2;
  localparam logic [1:0] OFF_STAT = 2'd3;

  logic mask_we;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  assign latch_we = bus_wr && (bus_win == WIN_TMR) && !bus_off[0];
  assign ctl_we   = bus_wr && (bus_win == WIN_TMR) &&  bus_off[0];
  assign ctl_en   = bus_wdata[0];
  assign latch_d  = bus_wdata[CNT_W-1:0];
  assign mask_we  = bus_wr && (bus_win == WIN_INT) && (bus_off == OFF_MASK);
  assign clr_tmr  = bus_wr && (bus_win == WIN_INT) && (bus_off == OFF_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_dis <= '0;
    end else if (mask_we) begin
      src_dis <= bus_wdata[NSRC-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_win == WIN_TMR) begin
      bus_rdata[CNT_W-1:0] = tmr_count;
    end else if (bus_off == OFF_MASK) begin
      bus_rdata[NSRC-1:0] = src_dis;
    end else if (bus_off == OFF_STAT) begin
      bus_rdata[NSRC-1:0] = src_pend;
    end
  end

  p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (src_dis == $past(bus_wdata[NSRC-1:0])));

  p_low_offsets_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_win == WIN_INT && !bus_off[1]) |=> $stable(src_dis));

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import tmrint_pkg::*;
#(
  parameter int NS = NSRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] pend,
  input  logic [NS-1:0] dis,
  input  logic          cpu_mask,
  input  logic          sample,
  output logic          req,
  output logic [15:0]   vec
);

  logic [NS-1:0] live;
  logic          hit;

  assign live = live_sources(pend, dis);
  assign hit  = (|live) && !cpu_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      vec <= '0;
    end else if (sample) begin
      req <= hit;
      if (hit) vec <= pick_vector(live);
    end
  end

  p_hold_between_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> ($stable(req) && $stable(vec)));

  p_cpu_mask_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && cpu_mask) |=> !req);

  p_ext_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !cpu_mask && pend[0] && !dis[0]) |=> (req && vec == VEC_EXT));

  p_vector_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (vec == VEC_EXT || vec == VEC_VID || vec == VEC_TMR));

endmodule

// File: rtl/cpu_timer_intc.sv
module cpu_timer_intc
  import tmrint_pkg::*;
#(
  parameter int PRESCALE_DIV = 1024,
  parameter int CNT_W        = 7,
  parameter int DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_win,
  input  logic [1:0]        reg_off,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_irq_lvl,
  input  logic              vid_irq_lvl,
  input  logic              cpu_int_mask,
  input  logic              insn_end,
  output logic              irq_req,
  output logic [15:0]       irq_vector
);

  logic             latch_we;
  logic [CNT_W-1:0] latch_d;
  logic             ctl_we;
  logic             ctl_en;
  logic             clr_tmr;
  logic [CNT_W-1:0] tmr_count;
  logic             tmr_pend;
  logic             tmr_tick;
  logic             tmr_wrap;
  logic [NSRC-1:0]  src_pend;
  logic [NSRC-1:0]  src_dis;

  always_comb begin
    src_pend          = '0;
    src_pend[SRC_EXT] = ext_irq_lvl;
    src_pend[SRC_VID] = vid_irq_lvl;
    src_pend[SRC_TMR] = tmr_pend;
  end

  tmrint_regs #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .NSRC   (NSRC)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (reg_wr),
    .bus_win   (reg_win),
    .bus_off   (reg_off),
    .bus_wdata (reg_wdata),
    .tmr_count (tmr_count),
    .src_pend  (src_pend),
    .latch_we  (latch_we),
    .latch_d   (latch_d),
    .ctl_we    (ctl_we),
    .ctl_en    (ctl_en),
    .clr_tmr   (clr_tmr),
    .src_dis   (src_dis),
    .bus_rdata (reg_rdata)
  );

  tmr_down_counter #(
    .PRESCALE_DIV (PRESCALE_DIV),
    .CNT_W        (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_we (latch_we),
    .latch_d  (latch_d),
    .ctl_we   (ctl_we),
    .ctl_en   (ctl_en),
    .clr_pend (clr_tmr),
    .count    (tmr_count),
    .pend     (tmr_pend),
    .tick     (tmr_tick),
    .wrap     (tmr_wrap)
  );

  intc_arbiter #(
    .NS (NSRC)
  ) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (src_pend),
    .dis      (src_dis),
    .cpu_mask (cpu_int_mask),
    .sample   (insn_end),
    .req      (irq_req),
    .vec      (irq_vector)
  );

  p_pending_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap |=> tmr_pend);

  p_clear_spares_levels_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tmr && !tmr_wrap && !tmr_tick) |=> !tmr_pend);

endmodule

// File: tb/cpu_timer_intc_bench.sv
module cpu_timer_intc_bench;

  localparam int DIV = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_win = 1'b0;
  logic [1:0]  reg_off = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        ext_irq_lvl = 1'b0;
  logic        vid_irq_lvl = 1'b0;
  logic        cpu_int_mask = 1'b0;
  logic        insn_end = 1'b1;
  logic        irq_req;
  logic [15:0] irq_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit ready = 0;
  bit done = 0;

  cpu_timer_intc u_cpu_timer_intc (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_win(reg_win),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ext_irq_lvl(ext_irq_lvl), .vid_irq_lvl(vid_irq_lvl),
    .cpu_int_mask(cpu_int_mask), .insn_end(insn_end),
    .irq_req(irq_req), .irq_vector(irq_vector)
  );

  always #4 clk = ~clk;

  // behavioural reference
  int m_lat, m_cnt, m_pre, m_en, m_tp, m_dis, m_req, m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat = 0; m_cnt = 0; m_pre = 0; m_en = 0;
      m_tp = 0; m_dis = 0; m_req = 0; m_vec = 0;
    end else begin : upd
      int n_cnt, n_pre, n_tp, pend, live;
      bit fire;
      n_cnt = m_cnt; n_pre = m_pre; n_tp = m_tp; fire = 0;
      pend = (m_tp << 2) | (int'(vid_irq_lvl) << 1) | int'(ext_irq_lvl);
      live = pend & ~m_dis & 7;
      if (m_en != 0) begin
        if (m_pre == DIV - 1) begin
          n_pre = 0;
          if (m_cnt == 0) begin n_cnt = m_lat; fire = 1; end
          else n_cnt = m_cnt - 1;
        end else n_pre = m_pre + 1;
      end
      if (reg_wr && reg_win && reg_off == 3) n_tp = 0;
      if (fire) n_tp = 1;
      if (insn_end) begin
        m_req = (live != 0 && !cpu_int_mask) ? 1 : 0;
        if (m_req != 0) begin
          if (live & 1) m_vec = 'hFFF6;
          else if (live & 2) m_vec = 'hFFF8;
          else m_vec = 'hFFFA;
        end
      end
      if (reg_wr && !reg_win && reg_off[0]) begin
        m_en = reg_wdata[0];
        if (reg_wdata[0]) begin n_cnt = m_lat; n_pre = 0; end
      end
      if (reg_wr && !reg_win && !reg_off[0]) m_lat = reg_wdata & 'h7F;
      if (reg_wr && reg_win && reg_off == 2) m_dis = reg_wdata & 7;
      m_cnt = n_cnt; m_pre = n_pre; m_tp = n_tp;
    end
  end

  function automatic int model_rd();
    if (!reg_win) return m_cnt;
    if (reg_off == 2) return m_dis;
    if (reg_off == 3) return (m_tp << 2) | (int'(vid_irq_lvl) << 1) | int'(ext_irq_lvl);
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (ready && !done) begin
      chk("R10 irq_req vs model", int'(irq_req), m_req);
      chk("R9 irq_vector vs model", int'(irq_vector), m_vec);
      chk("R2/R6/R7 reg_rdata vs model", int'(reg_rdata), model_rd());
    end
  end

  task automatic bus_wr(input bit win, input int off, input int data);
    reg_win = win; reg_off = 2'(off); reg_wdata = 8'(data); reg_wr = 1'b1;
    @(posedge clk); #2;
    reg_wr = 1'b0;
  endtask

  task automatic peek(input bit win, input int off, input int exp, input string tag);
    reg_win = win; reg_off = 2'(off);
    #1;
    chk(tag, int'(reg_rdata), exp);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); end
    #2;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    ready = 1;
    cyc(1);
    // R1 reset state
    chk("R1 irq_req after reset", int'(irq_req), 0);
    chk("R1 irq_vector after reset", int'(irq_vector), 0);
    peek(0, 0, 0, "R1 count after reset");
    peek(1, 2, 0, "R1 mask after reset");
    peek(1, 3, 0, "R1 status after reset");

    // R2 reload write does not touch count; R3 enable copies it
    bus_wr(0, 0, 8'h85);
    peek(0, 2, 0, "R2 count unchanged by reload write");
    bus_wr(0, 1, 1);
    peek(0, 0, 5, "R3 enable loads count from bits 6:0");
    // R4 one step per DIV clocks
    cyc(DIV - 1);
    peek(0, 1, 5, "R4 no step before DIV clocks");
    cyc(1);
    peek(0, 3, 4, "R4 step after DIV clocks");
    // R3 disable holds
    bus_wr(0, 1, 0);
    cyc(2 * DIV);
    peek(0, 0, 4, "R3 count holds while disabled");

    // R5 reload from zero sets pending
    bus_wr(0, 0, 1);
    insn_end = 1'b0;
    bus_wr(0, 1, 1);
    cyc(2 * DIV - 1);
    peek(1, 3, 0, "R5 no pending before reload");
    cyc(1);
    peek(0, 0, 1, "R5 count reloaded");
    peek(1, 3, 4, "R5 timer pending set");
    bus_wr(0, 1, 0);
    insn_end = 1'b1;
    cyc(1);
    chk("R9 timer alone gives FFFA", int'(irq_vector), 'hFFFA);

    // R7 levels visible live
    ext_irq_lvl = 1'b1; vid_irq_lvl = 1'b1;
    peek(1, 3, 7, "R7 status shows ext and vid levels");
    cyc(1);
    chk("R9 external wins", int'(irq_vector), 'hFFF6);
    ext_irq_lvl = 1'b0;
    cyc(1);
    chk("R9 video beats timer", int'(irq_vector), 'hFFF8);
    vid_irq_lvl = 1'b0;
    cyc(1);
    chk("R9 timer last", int'(irq_vector), 'hFFFA);
    // R6 mask timer
    bus_wr(1, 2, 8'hFC);
    peek(1, 2, 4, "R6 mask readback bits 2:0");
    cyc(1);
    chk("R9 masked source gives no request", int'(irq_req), 0);
    chk("R10 vector held without request", int'(irq_vector), 'hFFFA);

    // R10 sampling only at insn_end
    insn_end = 1'b0;
    bus_wr(1, 2, 0);
    cyc(3);
    chk("R10 no change without insn_end", int'(irq_req), 0);
    insn_end = 1'b1;
    cyc(1);
    chk("R10 request at insn_end", int'(irq_req), 1);
    cpu_int_mask = 1'b1;
    cyc(1);
    chk("R10 cpu mask blocks request", int'(irq_req), 0);
    chk("R10 vector held while blocked", int'(irq_vector), 'hFFFA);
    ext_irq_lvl = 1'b1;
    cpu_int_mask = 1'b0;
    cyc(1);
    chk("R10 request back with external", int'(irq_vector), 'hFFF6);
    ext_irq_lvl = 1'b0;

    // R8 clear only the timer flag
    vid_irq_lvl = 1'b1;
    bus_wr(1, 3, 8'h00);
    peek(1, 3, 2, "R8 clear keeps video level, drops timer");
    vid_irq_lvl = 1'b0;
    // R8 reload in the clearing edge wins
    bus_wr(0, 0, 0);
    bus_wr(0, 1, 1);
    cyc(DIV - 1);
    bus_wr(1, 3, 8'hFF);
    peek(1, 3, 4, "R8 reload same edge as clear leaves flag set");
    peek(0, 0, 0, "R5 reload of zero");
    bus_wr(0, 1, 0);

    // R11 low offsets of window 1
    bus_wr(1, 0, 8'hFF);
    bus_wr(1, 1, 8'hFF);
    peek(1, 0, 0, "R11 offset 0 reads zero");
    peek(1, 1, 0, "R11 offset 1 reads zero");
    peek(1, 2, 0, "R11 mask unchanged");
    peek(1, 3, 4, "R11 timer flag unchanged");

    // random mix checked by the model each clock
    bus_wr(0, 0, 2);
    bus_wr(0, 1, 1);
    for (int i = 0; i < 6000; i++) begin
      ext_irq_lvl = ($urandom % 8) == 0;
      vid_irq_lvl = ($urandom % 6) == 0;
      cpu_int_mask = ($urandom % 5) == 0;
      insn_end = ($urandom % 3) == 0;
      if (($urandom % 40) == 0) begin
        int sel;
        sel = $urandom % 4;
        if (sel == 0) bus_wr(1, 2, $urandom % 256);
        else if (sel == 1) bus_wr(1, 3, 0);
        else if (sel == 2) bus_wr(0, 0, $urandom % 4);
        else bus_wr(0, 1, 1);
      end else begin
        reg_win = 1'($urandom); reg_off = 2'($urandom);
        cyc(1);
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule